// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six condition and control flags of an 8-bit processor (negative, overflow, decimal, interrupt-disable, zero, carry). It also builds the status byte that is written to the stack when status is pushed. Each cycle, the instruction sequencer presents one operation code. The arithmetic unit may also offer new flag values together with a per-bit write mask. The register applies both on the next rising clock edge.

The operations are:
- explicit set and clear of carry, decimal and interrupt-disable;
- a clear-only operation for overflow, since no operation sets overflow directly;
- register transfers that refresh negative and zero from the moved byte;
- the transfer into the stack pointer, which leaves every flag alone;
- status pull and interrupt return, which reload all six flags from a stack byte;
- the break entry, which forces interrupt-disable on.

Any operation code not listed leaves the flags as they are.

Top module: `status_flags`

## Requirements
- R1: After an active-low reset the status byte reads 0x34: interrupt-disable at 1, the other five flags at 0, and the two spare bits at 1.
- R2: The status byte layout is N at bit 7, V at 6, D at 3, I at 2, Z at 1 and C at 0. Bits 5 and 4 always read 1.
- R3: Operation codes 1/2 set/clear C, 3/4 set/clear D and 5/6 set/clear I. Each changes only its own flag.
- R4: Operation code 7 clears V and changes no other flag. No operation code sets V.
- R5: Operation code 8 (flag-updating transfer) sets N to bit 7 of the transfer value and Z to 1 exactly when the transfer value is zero. The other flags are unchanged.
- R6: Operation codes 0 (idle), 9 (transfer into stack pointer), 13 (push) and the unused codes 14 and 15 change no flag.
- R7: Operation codes 10 (status pull) and 11 (interrupt return) load all six flags from the matching bits of the pulled byte. Pulled bits 5 and 4 are ignored.
- R8: Operation code 12 (break entry) sets I to 1 and leaves the other flags unchanged.
- R9: Every flag whose bit is set in the arithmetic write mask (status-byte layout) takes the matching bit of the arithmetic flag input. Mask bits 5 and 4 have no effect.
- R10: When an operation code and the arithmetic mask target the same flag in one cycle, the operation code wins. Arithmetic writes to flags the operation code does not touch still apply.
- R11: Every update appears on the status output one clock edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Flag operation code for this cycle |
| xfer_val_i | input | 8 | Byte moved by a register transfer |
| pull_val_i | input | 8 | Status byte read from the stack |
| alu_flags_i | input | 8 | New flag values from the arithmetic unit, status-byte layout |
| alu_mask_i | input | 8 | Per-flag write enable for alu_flags_i, status-byte layout |
| status_o | output | 8 | Current status byte, ready to push |

## Verification
All state sits in six flip-flops that drive status_o directly. A wrong flag therefore shows at the port on the first edge after the faulty update. It stays there until some later operation overwrites that flag, which can take many cycles for decimal or overflow. For this reason the bench compares the whole status byte after every cycle, not only the bit an operation targets. Any collateral change to an untouched flag, or a lost arithmetic write in a shared cycle, is caught on the edge where it happens.

// File: rtl/status_flags.sv
module status_flags #(
  parameter int OP_W = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   xfer_val_i,
  input  logic [DW-1:0]   pull_val_i,
  input  logic [DW-1:0]   alu_flags_i,
  input  logic [DW-1:0]   alu_mask_i,
  output logic [DW-1:0]   status_o
);
  localparam logic [OP_W-1:0] OP_SET_C = 1, OP_CLR_C = 2, OP_SET_D = 3, OP_CLR_D = 4;
  localparam logic [OP_W-1:0] OP_SET_I = 5, OP_CLR_I = 6, OP_CLR_V = 7, OP_XFER = 8;
  localparam logic [OP_W-1:0] OP_PULL = 10, OP_RTI = 11, OP_BRK = 12;
  // flag vector order: {N,V,D,I,Z,C}
  localparam int FN = 5, FV = 4, FD = 3, FI = 2, FZ = 1, FC = 0;

  logic [5:0] flg, nxt, a_val, a_msk, p_val;

  assign a_val = {alu_flags_i[7:6], alu_flags_i[3:0]};
  assign a_msk = {alu_mask_i[7:6], alu_mask_i[3:0]};
  assign p_val = {pull_val_i[7:6], pull_val_i[3:0]};
  assign status_o = {flg[FN], flg[FV], 2'b11, flg[FD:FC]};

  always_comb begin
    nxt = (flg & ~a_msk) | (a_val & a_msk);
    case (op_i)
      OP_SET_C: nxt[FC] = 1'b1;
      OP_CLR_C: nxt[FC] = 1'b0;
      OP_SET_D: nxt[FD] = 1'b1;
      OP_CLR_D: nxt[FD] = 1'b0;
      OP_SET_I: nxt[FI] = 1'b1;
      OP_CLR_I: nxt[FI] = 1'b0;
      OP_CLR_V: nxt[FV] = 1'b0;
      OP_XFER: begin
        nxt[FN] = xfer_val_i[DW-1];
        nxt[FZ] = (xfer_val_i == '0);
      end
      OP_PULL, OP_RTI: nxt = p_val;
      OP_BRK:   nxt[FI] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg <= 6'b000100;
    else        flg <= nxt;
  end
endmodule

module status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] xfer_val_i,
  input logic [7:0] pull_val_i,
  input logic [7:0] alu_mask_i,
  input logic [7:0] status_o
);
  assert_spare_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:4] == 2'b11);
  assert_clrv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd7 |=> !status_o[6]);
  assert_xfer_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd8 |=> status_o[1] == ($past(xfer_val_i) == 8'h00) && status_o[7] == $past(xfer_val_i[7]));
  assert_sp_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd9 && alu_mask_i == 8'h00) |=> $stable(status_o));
  assert_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd10 || op_i == 4'd11) |=> status_o[7:6] == $past(pull_val_i[7:6]) && status_o[3:0] == $past(pull_val_i[3:0]));
  assert_brk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd12 |=> status_o[2]);
endmodule

bind status_flags status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .xfer_val_i(xfer_val_i),
  .pull_val_i(pull_val_i), .alu_mask_i(alu_mask_i), .status_o(status_o)
);

// File: tb/tb_status_flags.sv
module tb_status_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] xv = '0, pv = '0, af = '0, am = '0;
  logic [7:0] st;
  int n_tests = 0, n_fail = 0;
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flags dut (.clk(clk), .rst_n(rst_n), .op_i(op), .xfer_val_i(xv),
    .pull_val_i(pv), .alu_flags_i(af), .alu_mask_i(am), .status_o(st));

  function automatic logic [7:0] expect_next(logic [7:0] s, logic [3:0] o,
      logic [7:0] x, logic [7:0] p, logic [7:0] f, logic [7:0] m);
    logic [7:0] r;
    logic [7:0] mm;
    mm = m & 8'hCF;
    r = (s & ~mm) | (f & mm);
    case (o)
      4'd1: r[0] = 1'b1;
      4'd2: r[0] = 1'b0;
      4'd3: r[3] = 1'b1;
      4'd4: r[3] = 1'b0;
      4'd5: r[2] = 1'b1;
      4'd6: r[2] = 1'b0;
      4'd7: r[6] = 1'b0;
      4'd8: begin r[7] = x[7]; r[1] = (x == 8'h00); end
      4'd10, 4'd11: r = p;
      4'd12: r[2] = 1'b1;
      default: ;
    endcase
    return r | 8'h30;
  endfunction

  function automatic string tag_of(logic [3:0] o, logic [7:0] m);
    if ((m & 8'hCF) != 0 && o inside {[4'd1:4'd8], 4'd10, 4'd11, 4'd12}) return "R10";
    if ((m & 8'hCF) != 0) return "R9";
    case (o)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R3";
      4'd7: return "R4";
      4'd8: return "R5";
      4'd10, 4'd11: return "R7";
      4'd12: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] exp);
    n_tests++;
    if (st !== exp) begin
      n_fail++;
      $display("FAIL %s: status=%02h expected=%02h", req, st, exp);
    end
  endtask

  // R11: drive at negedge, sample 1 time unit after the next posedge
  task automatic step(logic [3:0] o, logic [7:0] x, logic [7:0] p, logic [7:0] f, logic [7:0] m);
    @(negedge clk);
    op = o; xv = x; pv = p; af = f; am = m;
    model = expect_next(model, o, x, p, f, m);
    @(posedge clk); #1;
    check(tag_of(o, m), model);
    if (st[5:4] != 2'b11) begin n_fail++; $display("FAIL R2: status=%02h expected=%02h", st, st | 8'h30); end
    n_tests++;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: status=%02h expected=completion", st);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1 check("R1", 8'h34);
    @(negedge clk) rst_n = 1'b1;
    model = 8'h34;
    // R11: output holds the reset value until the first edge after inputs change
    @(negedge clk);
    op = 4'd1;
    #1 check("R11", 8'h34);
    @(posedge clk); #1;
    model = 8'h35;
    check("R11", 8'h35);
    // directed corners
    step(4'd2, 0, 0, 0, 0);           // R3 clear carry
    step(4'd3, 0, 0, 0, 0);           // R3 set decimal
    step(4'd6, 0, 0, 0, 0);           // R3 clear I
    step(4'd10, 0, 8'hFF, 0, 0);      // R7 pull all ones
    step(4'd7, 0, 0, 0, 0);           // R4 clear V only
    step(4'd9, 8'h00, 8'h00, 0, 0);   // R6 stack pointer transfer
    step(4'd13, 0, 0, 0, 0);          // R6 push
    step(4'd14, 0, 0, 0, 0);          // R6 unused code, V stays 0
    step(4'd15, 0, 0, 0, 0);          // R6 unused code
    step(4'd8, 8'h00, 0, 0, 0);       // R5 zero value
    step(4'd8, 8'h80, 0, 0, 0);       // R5 negative value
    step(4'd11, 0, 8'h00, 0, 0);      // R7 interrupt return, spare bits ignored
    step(4'd12, 0, 0, 0, 0);          // R8 break
    step(4'd0, 0, 0, 8'hFF, 8'h30);   // R9 spare mask bits ignored
    step(4'd0, 0, 0, 8'hC3, 8'hFF);   // R9 full mask
    step(4'd2, 0, 0, 8'h01, 8'h41);   // R10 op beats ALU on C, ALU writes V
    step(4'd10, 0, 8'h00, 8'hFF, 8'hFF); // R10 pull beats ALU
    step(4'd8, 8'h01, 0, 8'h82, 8'hC3);  // R10 transfer beats ALU on N,Z
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] m;
      m = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      step(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), m);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule